// File: doc/BRIEF.md
# Serial Two-Wire Paged Memory Slave

This block is a slave on the I2C two-wire bus. It gives the master access to a byte-addressed store of 256 locations and behaves like a small serial non-volatile memory. SCL and SDA arrive already synchronised to the system clock. The block finds START and STOP conditions and compares the 7-bit device address against a parameter. It answers on the bus through an open-drain pull-down enable: a 1 pulls SDA low.

A write transaction works in three steps. The master sends the word address, which loads the internal pointer. Data bytes then collect in a 16-entry page buffer, and only the low four pointer bits step as they arrive. Nothing reaches the store until STOP. At that point every buffered byte is committed in one clock, and a programming window of a set number of system clocks begins. During that window the block stays silent on the bus.

Reads stream bytes from the pointer, which steps across the full address range. The stream continues for as long as the master acknowledges each byte.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset the SDA pull-down is released (sda_oe = 0) and every store location reads as 0xFF.
- R2: The address byte (7 address bits, then the R/W bit, MSB first) is acknowledged only when its upper seven bits equal DEV_ADDR. On a mismatch SDA stays released for the rest of the transaction and nothing is written.
- R3: In a write (R/W = 0), the byte after the address byte is acknowledged and loads the 8-bit pointer.
- R4: Each write data byte is acknowledged and placed at {pointer[7:4], pointer[3:0]}. Then pointer[3:0] increments modulo 16 and pointer[7:4] does not change.
- R5: When more than 16 data bytes arrive before STOP, the later bytes overwrite the earlier buffered bytes at the wrapped positions.
- R6: Buffered bytes reach the store only on STOP, all together. A read issued through a repeated START before that STOP returns the old contents. A STOP with no data byte buffered starts no programming window.
- R7: For PROG_CYCLES clocks after a committing STOP, the block acknowledges nothing, not even its own address. Once the window ends it acknowledges again.
- R8: In a read (R/W = 1), the block sends the byte at the pointer MSB first, then increments the pointer with wrap from 255 to 0. It continues with the next byte whenever the master acknowledges.
- R9: After the master answers a read byte with NACK, the block drives SDA no more until the next START or STOP.
- R10: The block asserts its SDA pull-down only while SCL is low.
- R11: A START at any point, including in the middle of a byte, abandons the current byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Synchronised bus clock |
| sda_in | input | 1 | Synchronised bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that the master acts as a well-behaved bus master. SCL is held level for several system clocks, and SDA changes only while SCL is low, except for the deliberate START and STOP edges. No START or STOP falls inside a window where the slave is driving. The bench master divides every bit into four equal phases of several clocks and changes SDA only in the phase after SCL falls, so it keeps to these conditions. It checks each bit against a behavioural model of the store, the pending page and the busy window. Busy-window probes are placed well inside or well outside PROG_CYCLES, so no check depends on the exact boundary cycle.

// File: rtl/i2c_ee_pkg.sv
// Shared types for the two-wire paged memory slave.
package i2c_ee_pkg;
    // Bus-side protocol phase of the slave controller.
    typedef enum logic [2:0] {
        S_IDLE,    // waiting for START
        S_DEV,     // shifting in the device address byte
        S_WADDR,   // shifting in the word address byte
        S_WDATA,   // shifting in write data bytes
        S_ACK,     // holding SDA low during the ninth clock
        S_TX,      // shifting out a read byte
        S_RACK,    // sampling the master acknowledge after a read byte
        S_IGNORE   // released, waiting for START or STOP
    } ee_state_t;
endpackage

// File: rtl/i2c_bus_events.sv
// Bus condition detector.
// Registers the synchronised SCL/SDA levels once and reports SCL edges,
// START (SDA falls while SCL high) and STOP (SDA rises while SCL high).
// Assumes both inputs are already synchronised to clk.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Previous-sample registers; the idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        start_ev = scl & scl_q & sda_q & ~sda;
        stop_ev  = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/ee_prog_timer.sv
// Programming window timer.
// A kick loads PROG_CYCLES; busy stays high until the count runs out.
module ee_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Down-counter holding the remaining window length.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (kick)        cnt_q <= CW'(PROG_CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/ee_page_store.sv
// Page buffer and byte store.
// Write data goes into a page buffer indexed by the low PW address bits.
// The upper bits are taken from the first byte of the page. A commit copies
// every valid buffer entry into the store in one clock. Reads see only
// committed contents. Assumes wr_en and commit never coincide.
module ee_page_store #(
    parameter int          AW     = 8,
    parameter int          PW     = 4,
    parameter logic [7:0]  ERASED = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          pending
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;

    logic [7:0]      mem_q  [DEPTH];
    logic [7:0]      page_q [PAGE];
    logic [PAGE-1:0] valid_q;
    logic [AW-PW-1:0] base_q;

    // Page data capture; contents only matter where valid_q is set.
    always_ff @(posedge clk) begin
        if (wr_en) page_q[wr_addr[PW-1:0]] <= wr_data;
    end

    // Valid bits, page base and committed store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            base_q  <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++)
                if (valid_q[i]) mem_q[{base_q, PW'(i)}] <= page_q[i];
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_addr[PW-1:0]] <= 1'b1;
            if (valid_q == '0) base_q <= wr_addr[AW-1:PW];
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign pending = |valid_q;

    // R6: a commit always empties the page buffer.
    p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pending);
endmodule

// File: rtl/i2c_ee_slave.sv
// Two-wire paged memory slave, top level.
// Decodes the bus protocol, drives the open-drain pull-down enable, steps
// the address pointer and starts a programming window on a committing STOP.
// Assumes SCL/SDA are synchronised and every SCL level lasts several clocks.
module i2c_ee_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         PROG_CYCLES = 1000,
    parameter int         AW          = 8,
    parameter int         PW          = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda_in,
    output logic sda_oe
);
    import i2c_ee_pkg::*;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic busy, pending, commit, wr_en;
    logic [7:0] rd_data;

    ee_state_t     state_q, after_q;
    logic [3:0]    bit_cnt_q;
    logic [7:0]    shreg_q;
    logic [7:0]    tx_q;
    logic [AW-1:0] ptr_q;
    logic          m_ack_q;
    logic          oe_q;

    i2c_bus_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    ee_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
    );

    ee_page_store #(.AW(AW), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(ptr_q), .wr_data(shreg_q),
        .commit(commit), .rd_addr(ptr_q), .rd_data(rd_data),
        .pending(pending)
    );

    // Strobes: buffer a completed data byte; commit on STOP with data.
    always_comb begin
        wr_en  = (state_q == S_WDATA) && scl_fall && (bit_cnt_q == 4'd8)
                 && !start_ev && !stop_ev;
        commit = stop_ev && pending;
    end

    // Protocol sequencer: shifting, acknowledge, read streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            after_q   <= S_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            tx_q      <= '0;
            ptr_q     <= '0;
            m_ack_q   <= 1'b0;
            oe_q      <= 1'b0;
        end else if (start_ev) begin
            state_q   <= S_DEV;
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
        end else if (stop_ev) begin
            state_q   <= S_IDLE;
            oe_q      <= 1'b0;
        end else begin
            case (state_q)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (scl_rise && bit_cnt_q < 4'd8) begin
                        shreg_q   <= {shreg_q[6:0], sda_in};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (scl_fall && bit_cnt_q == 4'd8) begin
                        bit_cnt_q <= '0;
                        if (state_q == S_DEV) begin
                            if (shreg_q[7:1] == DEV_ADDR && !busy) begin
                                oe_q    <= 1'b1;
                                state_q <= S_ACK;
                                after_q <= shreg_q[0] ? S_TX : S_WADDR;
                            end else begin
                                state_q <= S_IGNORE;
                            end
                        end else if (state_q == S_WADDR) begin
                            ptr_q   <= shreg_q;
                            oe_q    <= 1'b1;
                            state_q <= S_ACK;
                            after_q <= S_WDATA;
                        end else begin
                            ptr_q[PW-1:0] <= ptr_q[PW-1:0] + 1'b1;
                            oe_q    <= 1'b1;
                            state_q <= S_ACK;
                            after_q <= S_WDATA;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        state_q   <= after_q;
                        if (after_q == S_TX) begin
                            tx_q  <= rd_data;
                            ptr_q <= ptr_q + 1'b1;
                            oe_q  <= ~rd_data[7];
                        end else begin
                            oe_q  <= 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt_q == 4'd8) begin
                            oe_q    <= 1'b0;
                            state_q <= S_RACK;
                        end else begin
                            oe_q <= ~tx_q[3'd7 - bit_cnt_q[2:0]];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        m_ack_q <= ~sda_in;
                    end else if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (m_ack_q) begin
                            state_q <= S_TX;
                            tx_q    <= rd_data;
                            ptr_q   <= ptr_q + 1'b1;
                            oe_q    <= ~rd_data[7];
                        end else begin
                            state_q <= S_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe_q;

    // R10: the pull-down is switched on only while SCL is low.
    p_oe_on_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl);

    // R7: silent on the bus throughout the programming window.
    p_silent_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R4: a buffered byte advances the low pointer bits only.
    p_page_high_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW])) &&
                  (ptr_q[PW-1:0] == $past(ptr_q[PW-1:0]) + 1'b1));

    // R6: a programming window opens only right after a STOP.
    p_window_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev));

    // R2: a mismatching address byte is never acknowledged.
    p_mismatch_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEV && scl_fall && bit_cnt_q == 4'd8 &&
         shreg_q[7:1] != DEV_ADDR) |=> !sda_oe);

    // R11: START restarts address reception with the line released.
    p_start_restarts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state_q == S_DEV) && !sda_oe);
endmodule

// File: tb/i2c_ee_slave_tb_top.sv
// Bench: bit-level bus master plus a behavioural model of store, page and window.
module i2c_ee_slave_tb_top;
    localparam int         PROG = 300;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         Q    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_in = sda_m & ~sda_oe;

    always #4 clk = ~clk;   // 125 MHz

    i2c_ee_slave #(.DEV_ADDR(DEV), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_in), .sda_oe(sda_oe)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int commit_cyc = -100000;
    int r10_viol = 0;
    bit finished = 0;

    logic [7:0] mem_m  [256];
    logic [7:0] pend_d [256];
    bit         pend_v [256];
    logic [7:0] ptr_m;

    always @(posedge clk) cyc <= cyc + 1;

    // R10 monitor: pull-down may switch on only while SCL is low.
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && scl) r10_viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit busy_m();
        return (cyc - commit_cyc) < PROG;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        bit any = 0;
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
        for (int a = 0; a < 256; a++)
            if (pend_v[a]) begin
                mem_m[a] = pend_d[a];
                pend_v[a] = 0;
                any = 1;
            end
        if (any) commit_cyc = cyc;
    endtask

    task automatic bus_bit(input logic b, output logic line);
        sda_m = b;  tick(Q);
        scl = 1'b1; tick(Q);
        line = sda_in;
        tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    // Master sends a byte; checks the line for contention, then the ACK bit.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic [7:0] got;
        logic l;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(b[i], l);
            got[i] = l;
        end
        chk(got == b, {tag, " line"}, got, b);
        bus_bit(1'b1, l);
        chk((l == 1'b0) == exp_ack, {tag, " ack"}, ~l, exp_ack);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit ack, input string tag);
        logic [7:0] got;
        logic l;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, l);
            got[i] = l;
        end
        chk(got == exp, tag, got, exp);
        bus_bit(~ack, l);
    endtask

    task automatic write_txn(input logic [6:0] dev, input logic [7:0] waddr,
                             input logic [7:0] data[$], input bit do_stop,
                             input string tag);
        bit ok;
        ok = (dev == DEV) && !busy_m();
        bus_start();
        send_byte({dev, 1'b0}, ok, {tag, " dev"});
        send_byte(waddr, ok, {tag, " waddr"});
        if (ok) ptr_m = waddr;
        foreach (data[k]) begin
            send_byte(data[k], ok, {tag, " data"});
            if (ok) begin
                pend_d[ptr_m] = data[k];
                pend_v[ptr_m] = 1;
                ptr_m = {ptr_m[7:4], ptr_m[3:0] + 4'd1};
            end
        end
        if (do_stop) bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] addr, input int n, input bit nack_probe,
                            input string tag);
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, {tag, " dev"});
        send_byte(addr, 1'b1, {tag, " raddr"});
        ptr_m = addr;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, {tag, " devr"});
        for (int i = 0; i < n; i++) begin
            recv_byte(mem_m[ptr_m], i < n - 1, tag);
            ptr_m = ptr_m + 8'd1;
        end
        if (nack_probe) send_byte(8'hFF, 1'b0, "R9 after nack");
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[$];
        logic l;
        for (int a = 0; a < 256; a++) begin
            mem_m[a] = 8'hFF;
            pend_v[a] = 0;
        end
        ptr_m = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);

        read_txn(8'h10, 2, 0, "R1 R8 erased read");

        d = '{8'hA1, 8'hA2, 8'hA3};
        write_txn(DEV, 8'h23, d, 1, "R3 R4 write");
        d = '{8'h55};
        write_txn(DEV, 8'h40, d, 1, "R7 busy probe");
        tick(400);
        write_txn(DEV, 8'h41, d, 1, "R7 window over");
        tick(400);
        read_txn(8'h22, 5, 0, "R3 R4 readback");

        d.delete();
        for (int i = 0; i < 18; i++) d.push_back(8'h80 + 8'(i));
        write_txn(DEV, 8'h5E, d, 1, "R5 page wrap");
        tick(400);
        read_txn(8'h50, 17, 0, "R4 R5 page readback");

        d.delete();
        write_txn(DEV, 8'h70, d, 1, "R6 empty write");
        d = '{8'h99};
        write_txn(DEV, 8'h71, d, 1, "R6 no window");
        tick(400);

        d = '{8'h11};
        write_txn(DEV, 8'h80, d, 0, "R6 held write");
        read_txn(8'h80, 1, 0, "R6 before stop");
        tick(400);
        read_txn(8'h80, 1, 0, "R6 after stop");

        d = '{8'h42};
        write_txn(DEV, 8'hFF, d, 1, "R8 prep");
        tick(400);
        read_txn(8'hFE, 4, 1, "R8 R9 wrap read");

        d = '{8'hEE};
        write_txn(7'h51, 8'h30, d, 1, "R2 mismatch");
        tick(20);
        read_txn(8'h30, 1, 0, "R2 no write");

        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(i[0], l);
        d = '{8'h77};
        write_txn(DEV, 8'h90, d, 1, "R11 restart");
        tick(400);
        read_txn(8'h90, 1, 0, "R11 readback");

        chk(r10_viol == 0, "R10 pull-down with SCL high", r10_viol, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule